// File: doc/BRIEF.md
# Asynchronous Static RAM Controller with Byte Lanes

This block connects a synchronous request port to an external asynchronous static RAM of 16-bit words. A request carries a word address, write data and a two-bit lane mask, and it is accepted through a valid/ready handshake. The controller then drives the RAM's active-low chip select, write strobe, output enable and per-lane enables. It holds them for a fixed number of clock cycles, derived from the clock period and the RAM's access time. For a read, it returns the sampled word with a one-cycle valid pulse.

The shared data bus is handled as a separate output path, output-enable and input path. The controller drives the bus for the whole of a write, including the cycle after the write strobe rises. It never drives the bus during a read or in the cycle that follows one. Lanes that are not selected by the mask are neither written nor returned. A request whose mask is all zero completes without touching the RAM.

Top module: `sram_ctl`

## Requirements
- R1: While no access is in progress, chip select, write strobe, output enable and both lane enables are high, the bus output enable is low, and `req_ready` is high.
- R2: A request is taken on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` stays low until the access ends: it is high again in cycle W+2 after the accepting edge for an access with a non-zero mask, and in cycle 2 after it for an access with a zero mask.
- R3: The access length W equals ceil((ACCESS_PS+MARGIN_PS)/CLK_PERIOD_PS), with a minimum of 1. With the defaults (10 ns period, 10 ns access time, 2 ns margin) W is 2.
- R4: A write holds chip select and write strobe low for cycles 1 to W after acceptance. During those cycles output enable is high, the bus is driven, the address and data are the requested ones, and the lane enables equal the inverted mask. Mask bit 0 selects data bits 7:0 (lane enable 0), and mask bit 1 selects bits 15:8 (lane enable 1).
- R5: In cycle W+1 of a write, the write strobe is high while chip select stays low. In that cycle the bus is still driven, and the address, data and lane enables are unchanged.
- R6: A read holds chip select and output enable low with the write strobe high and the bus released for cycles 1 to W. The bus is sampled on the last of those edges. `rsp_valid` is high for exactly cycle W+1.
- R7: In read data, a lane whose mask bit is clear returns zero, whatever the bus carries on that lane.
- R8: In the cycle after output enable rises at the end of a read, the bus output enable is still low. The bus is never driven while the RAM drives it.
- R9: A request with mask 0 asserts no strobe. A zero-mask write leaves memory unchanged. A zero-mask read gives `rsp_valid` in cycle 1 with data 0.
- R10: A write changes only the selected lanes of the addressed word. The other lane and all other words keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (17) | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Lane mask, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | 16 | Read data, unselected lanes zero |
| sram_addr | output | ADDR_W (17) | RAM address |
| sram_ce_n | output | 1 | RAM chip select, active low |
| sram_we_n | output | 1 | RAM write strobe, active low |
| sram_oe_n | output | 1 | RAM output enable, active low |
| sram_lane_n | output | 2 | RAM lane enables, active low, bit 0 = low byte |
| sram_dq_out | output | 16 | Data toward the bus |
| sram_dq_oe | output | 1 | Bus driver enable |
| sram_dq_in | input | 16 | Data from the bus |

## Verification
Every result is tied to the accepting clock edge. Strobes and the bus driver are active in cycles 1 to W, and the write-hold state or the read data valid falls in cycle W+1. Ready returns in cycle W+2, or in cycles 1 and 2 for a zero-mask request. The bench drives inputs and samples outputs on the falling edge and counts falling edges from acceptance, checking each output in exactly its due cycle. A behavioural RAM model stores data on the rising write strobe, drives only the enabled lanes and fills unselected lanes with a non-zero pattern. It also flags any cycle in which both sides drive the bus.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR,
        ST_WHOLD,
        ST_RD,
        ST_TURN,
        ST_NOP
    } ctl_st_e;
endpackage

// File: rtl/sram_wait_cnt.sv
module sram_wait_cnt #(
    parameter int WAIT_CYC = 2,
    parameter int CNT_W    = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expired
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = CNT_W'(WAIT_CYC - 1);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/sram_lane_mask.sv
module sram_lane_mask #(
    parameter int LANES = 2
) (
    input  logic [LANES*8-1:0] din,
    input  logic [LANES-1:0]   lane_en,
    output logic [LANES*8-1:0] dout
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign dout[g*8 +: 8] = lane_en[g] ? din[g*8 +: 8] : 8'h00;
    end
endmodule

// File: rtl/sram_ctl.sv
module sram_ctl #(
    parameter int ADDR_W        = 17,
    parameter int CLK_PERIOD_PS = 10000,
    parameter int ACCESS_PS     = 10000,
    parameter int MARGIN_PS     = 2000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [15:0]       req_wdata,
    input  logic [1:0]        req_be,
    output logic              rsp_valid,
    output logic [15:0]       rsp_rdata,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_ce_n,
    output logic              sram_we_n,
    output logic              sram_oe_n,
    output logic [1:0]        sram_lane_n,
    output logic [15:0]       sram_dq_out,
    output logic              sram_dq_oe,
    input  logic [15:0]       sram_dq_in
);
    import sram_ctl_pkg::*;

    localparam int DATA_W   = 16;
    localparam int LANES    = DATA_W / 8;
    localparam int WAIT_RAW = (ACCESS_PS + MARGIN_PS + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
    localparam int WAIT_CYC = (WAIT_RAW < 1) ? 1 : WAIT_RAW;
    localparam int CNT_W    = $clog2(WAIT_CYC) + 1;

    typedef struct packed {
        ctl_st_e           st;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [LANES-1:0]  lane_n;
        logic              ce_n;
        logic              we_n;
        logic              oe_n;
        logic              dq_oe;
        logic [DATA_W-1:0] rdata;
        logic              rvalid;
    } ctl_s;

    ctl_s ctl_d, ctl_q;
    logic cnt_load, cnt_expired;
    logic [DATA_W-1:0] masked_rd;

    sram_wait_cnt #(.WAIT_CYC(WAIT_CYC), .CNT_W(CNT_W)) u_wait (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (cnt_load),
        .expired (cnt_expired)
    );

    sram_lane_mask #(.LANES(LANES)) u_mask (
        .din     (sram_dq_in),
        .lane_en (~ctl_q.lane_n),
        .dout    (masked_rd)
    );

    always_comb begin
        ctl_d        = ctl_q;
        ctl_d.rvalid = 1'b0;
        cnt_load     = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    ctl_d.addr   = req_addr;
                    ctl_d.wdata  = req_wdata;
                    ctl_d.lane_n = ~req_be;
                    if (req_be == '0) begin
                        ctl_d.st     = ST_NOP;
                        ctl_d.rvalid = !req_write;
                        ctl_d.rdata  = '0;
                    end else begin
                        ctl_d.ce_n = 1'b0;
                        cnt_load   = 1'b1;
                        if (req_write) begin
                            ctl_d.st    = ST_WR;
                            ctl_d.we_n  = 1'b0;
                            ctl_d.dq_oe = 1'b1;
                        end else begin
                            ctl_d.st   = ST_RD;
                            ctl_d.oe_n = 1'b0;
                        end
                    end
                end
            end
            ST_WR: begin
                if (cnt_expired) begin
                    ctl_d.st   = ST_WHOLD;
                    ctl_d.we_n = 1'b1;
                end
            end
            ST_WHOLD: begin
                ctl_d.st     = ST_IDLE;
                ctl_d.ce_n   = 1'b1;
                ctl_d.lane_n = '1;
                ctl_d.dq_oe  = 1'b0;
            end
            ST_RD: begin
                if (cnt_expired) begin
                    ctl_d.st     = ST_TURN;
                    ctl_d.rdata  = masked_rd;
                    ctl_d.rvalid = 1'b1;
                    ctl_d.oe_n   = 1'b1;
                    ctl_d.ce_n   = 1'b1;
                    ctl_d.lane_n = '1;
                end
            end
            ST_TURN: ctl_d.st = ST_IDLE;
            ST_NOP:  begin
                ctl_d.st     = ST_IDLE;
                ctl_d.lane_n = '1;
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.st     <= ST_IDLE;
            ctl_q.addr   <= '0;
            ctl_q.wdata  <= '0;
            ctl_q.lane_n <= '1;
            ctl_q.ce_n   <= 1'b1;
            ctl_q.we_n   <= 1'b1;
            ctl_q.oe_n   <= 1'b1;
            ctl_q.dq_oe  <= 1'b0;
            ctl_q.rdata  <= '0;
            ctl_q.rvalid <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign req_ready   = (ctl_q.st == ST_IDLE);
    assign rsp_valid   = ctl_q.rvalid;
    assign rsp_rdata   = ctl_q.rdata;
    assign sram_addr   = ctl_q.addr;
    assign sram_ce_n   = ctl_q.ce_n;
    assign sram_we_n   = ctl_q.we_n;
    assign sram_oe_n   = ctl_q.oe_n;
    assign sram_lane_n = ctl_q.lane_n;
    assign sram_dq_out = ctl_q.wdata;
    assign sram_dq_oe  = ctl_q.dq_oe;
endmodule

// File: rtl/sram_ctl_chk.sv
module sram_ctl_chk #(
    parameter int ADDR_W = 17
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] sram_addr,
    input logic              sram_ce_n,
    input logic              sram_we_n,
    input logic              sram_oe_n,
    input logic [1:0]        sram_lane_n,
    input logic [15:0]       sram_dq_out,
    input logic              sram_dq_oe
);
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (sram_ce_n && sram_we_n && sram_oe_n && sram_lane_n == 2'b11 && !sram_dq_oe));

    // R2
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_ce_n |-> !req_ready);

    // R4
    write_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> (!sram_ce_n && sram_oe_n && sram_dq_oe));

    // R5
    write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |=> ($stable(sram_addr) && $stable(sram_dq_out) && $stable(sram_lane_n)
                        && !sram_ce_n && sram_dq_oe));

    // R6
    read_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_oe_n |-> (sram_we_n && !sram_ce_n && !sram_dq_oe));

    // R6
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R8
    turnaround_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_oe_n) |=> !sram_dq_oe);

    // R9
    empty_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sram_lane_n == 2'b11) |-> (sram_we_n && sram_oe_n));
endmodule

bind sram_ctl sram_ctl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_ready   (req_ready),
    .rsp_valid   (rsp_valid),
    .sram_addr   (sram_addr),
    .sram_ce_n   (sram_ce_n),
    .sram_we_n   (sram_we_n),
    .sram_oe_n   (sram_oe_n),
    .sram_lane_n (sram_lane_n),
    .sram_dq_out (sram_dq_out),
    .sram_dq_oe  (sram_dq_oe)
);

// File: tb/test_sram_ctl.sv
module test_sram_ctl;
    localparam int AW    = 8;
    localparam int DEPTH = 1 << AW;
    // R3: ceil((10000 + 2000) / 10000) = 2
    localparam int W     = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0] req_be = '0;
    logic req_ready, rsp_valid, sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe;
    logic [15:0] rsp_rdata, sram_dq_out, sram_dq_in;
    logic [AW-1:0] sram_addr;
    logic [1:0] sram_lane_n;

    logic [15:0] mem [DEPTH];
    logic [15:0] expm [DEPTH];
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    sram_ctl #(.ADDR_W(AW)) i_sram_ctl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .sram_addr(sram_addr),
        .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n),
        .sram_lane_n(sram_lane_n), .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe),
        .sram_dq_in(sram_dq_in)
    );

    // RAM model: drives only enabled lanes, filler pattern elsewhere
    logic ram_drive;
    assign ram_drive = !sram_ce_n && !sram_oe_n && sram_we_n && (sram_lane_n != 2'b11);
    assign sram_dq_in = ram_drive ?
        {sram_lane_n[1] ? 8'hA5 : mem[sram_addr][15:8], sram_lane_n[0] ? 8'h5A : mem[sram_addr][7:0]}
        : 16'hC3C3;

    always @(posedge sram_we_n) begin
        if (rst_n && sram_ce_n === 1'b0) begin
            if (!sram_lane_n[0]) mem[sram_addr][7:0]  = sram_dq_out[7:0];
            if (!sram_lane_n[1]) mem[sram_addr][15:8] = sram_dq_out[15:8];
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // R8: no cycle with both sides driving the bus
    always @(negedge clk) begin
        if (rst_n && !done) chk(!(sram_dq_oe && ram_drive), "R8 contention", {sram_dq_oe, ram_drive}, 0);
    end

    function automatic logic [15:0] pat(input int a, input int salt);
        return 16'((a * 16'h3B1 + salt * 16'h1F07) ^ (a << 7));
    endfunction

    function automatic logic [15:0] lanes(input logic [15:0] v, input logic [1:0] be);
        return {be[1] ? v[15:8] : 8'h00, be[0] ? v[7:0] : 8'h00};
    endfunction

    task automatic access(input logic wr, input logic [AW-1:0] a, input logic [15:0] d, input logic [1:0] be);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        if (be == 2'b00) begin
            // R9 cycle 1
            chk(sram_ce_n && sram_we_n && sram_oe_n && sram_lane_n == 2'b11, "R9 strobes",
                {sram_ce_n, sram_we_n, sram_oe_n, sram_lane_n}, 5'h1F);
            chk(rsp_valid == !wr, "R9 rsp_valid", rsp_valid, !wr);
            if (!wr) chk(rsp_rdata == 16'h0, "R9 rdata", rsp_rdata, 0);
            @(negedge clk);
            chk(req_ready, "R2 ready zero-mask", req_ready, 1);
            return;
        end
        for (int k = 1; k <= W; k++) begin
            chk(!req_ready, "R2 busy", req_ready, 0);
            chk(sram_addr == a && sram_lane_n == ~be, "R4/R6 addr lanes", {sram_addr, sram_lane_n}, {a, ~be});
            if (wr) begin
                chk(!sram_ce_n && !sram_we_n && sram_oe_n && sram_dq_oe && sram_dq_out == d, "R4 write",
                    {sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe, sram_dq_out}, {4'b0011, d});
            end else begin
                chk(!sram_ce_n && !sram_oe_n && sram_we_n && !sram_dq_oe && !rsp_valid, "R6 read",
                    {sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe, rsp_valid}, 5'b00100);
            end
            @(negedge clk);
        end
        if (wr) begin
            chk(!sram_ce_n && sram_we_n && sram_dq_oe && sram_addr == a && sram_dq_out == d
                && sram_lane_n == ~be, "R5 hold",
                {sram_ce_n, sram_we_n, sram_dq_oe, sram_dq_out}, {3'b011, d});
            if (be[0]) expm[a][7:0]  = d[7:0];
            if (be[1]) expm[a][15:8] = d[15:8];
        end else begin
            chk(rsp_valid, "R6 valid", rsp_valid, 1);
            chk(rsp_rdata == lanes(expm[a], be), "R7 rdata", rsp_rdata, lanes(expm[a], be));
            chk(sram_oe_n && !sram_dq_oe, "R8 turn", {sram_oe_n, sram_dq_oe}, 2'b10);
        end
        @(negedge clk);
        chk(req_ready && !rsp_valid, "R2 ready back", {req_ready, rsp_valid}, 2'b10);
        chk(sram_ce_n && sram_we_n && sram_oe_n && sram_lane_n == 2'b11 && !sram_dq_oe, "R1 idle",
            {sram_ce_n, sram_we_n, sram_oe_n, sram_lane_n, sram_dq_oe}, 6'b111110);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int a = 0; a < DEPTH; a++) begin
            mem[a] = pat(a, 0);
            expm[a] = pat(a, 0);
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(req_ready && !rsp_valid && sram_ce_n && sram_we_n && sram_oe_n && sram_lane_n == 2'b11
            && !sram_dq_oe, "R1 reset", {req_ready, rsp_valid, sram_ce_n, sram_dq_oe}, 4'b1010);
        for (int a = 0; a < DEPTH; a++) access(1'b0, AW'(a), 16'h0, 2'b11);
        for (int a = 0; a < DEPTH; a++) access(1'b1, AW'(a), pat(a, 1), 2'b11);
        // R10: lane-selective writes, including zero mask (R9)
        for (int a = 0; a < DEPTH; a++) access(1'b1, AW'(a), pat(a, 2), 2'(a % 4));
        // R7: lane-selective reads
        for (int a = 0; a < DEPTH; a++) access(1'b0, AW'(a), 16'h0, 2'((a + 1) % 4));
        // read straight after write and write straight after read (R8)
        for (int a = 0; a < 16; a++) begin
            access(1'b0, AW'(a), 16'h0, 2'b11);
            access(1'b1, AW'(a), pat(a, 3), 2'b10);
        end
        for (int a = 0; a < DEPTH; a++) begin
            access(1'b0, AW'(a), 16'h0, 2'b11);
            chk(mem[a] == expm[a], "R10 contents", mem[a], expm[a]);
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule